// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synchronous static RAM whose address, data and control inputs are all captured on the rising clock edge. Reads come back through an output register one cycle after the access is registered. Each word is made of four 9-bit lanes, and the top bit of each lane is a parity bit. Writes can cover any subset of the lanes through per-lane enables gated by a byte-write enable. A global write strobe overrides the lane enables and writes the full word.

An access starts from one of two address strobes. The processor-side strobe counts only while the primary chip enable is low. The controller-side strobe counts unconditionally. The access then goes ahead only if all three chip enables decode as selected. Once a burst is open, an advance input steps a 2-bit counter through the four words of the aligned group, in either interleaved or linear order.

The output enable works without a clock. An asynchronous sleep input passes through a synchronizer and then blocks new accesses. When the block is deselected, the outputs stay driven for one extra cycle before they are released. The array depth is a parameter. The default of 512 words keeps elaboration small, and setting `AW` to 15 gives the full 32K-word array.

Top module: `sbsram_pipe`

## Requirements
- R1: An access that a strobe starts is performed only when `sel_n`=0, `sel_hi`=1 and `sel2_n`=0. A strobe seen with any other enable combination deselects the block, and nothing is written or read.
- R2: `strp_n`=0 starts an access only while `sel_n`=0. `strc_n`=0 starts one regardless of `sel_n`.
- R3: With `all_wr_n`=0, all four lanes of the addressed word are written, whatever `byte_wr_n` and `lane_we_n` hold.
- R4: With `all_wr_n`=1 and `byte_wr_n`=0, each lane i whose `lane_we_n[i]`=0 has bits [9i+8:9i] written from `din`, parity bit 9i+8 included. The other lanes keep their contents.
- R5: A registered access is a write only if it enables at least one lane under R3 or R4. Otherwise it is a read: the memory is unchanged and the addressed word is returned. During a write cycle the output is not driven.
- R6: Take a read registered at rising edge k. Its word appears on `dout`, with `dout_vld`=1, after edge k+1.
- R7: While a burst is open and no strobe is active, `adv_n`=0 advances the 2-bit count and `adv_n`=1 holds it. Each such cycle accesses {base[AW-1:2], low}. The value low is base[1:0] XOR count when `lin_burst` was 0 at the start, and (base[1:0] + count) mod 4 when it was 1.
- R8: `oe_n`=1 forces `dout_vld`=0 and `dout`=0 straight away, without waiting for a clock. Dropping `oe_n` restores the registered output.
- R9: Take a read whose data is driven after edge k+1, followed by deselect cycles. The data stays driven after edge k+2 and is released after edge k+3.
- R10: While synchronized `sleep` is high, strobes are ignored: no write happens and no read data is produced. Memory contents are preserved.
- R11: During and right after reset, `dout_vld`=0 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address |
| din | input | 36 | Write data, four 9-bit lanes |
| sel_n | input | 1 | Primary chip enable, active low |
| sel_hi | input | 1 | Expansion enable, active high |
| sel2_n | input | 1 | Expansion enable, active low |
| strp_n | input | 1 | Processor-side address strobe, active low |
| strc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| byte_wr_n | input | 1 | Lane-write gate, active low |
| all_wr_n | input | 1 | Global write, active low |
| lin_burst | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request |
| dout | output | 36 | Read data, zero when not driven |
| dout_vld | output | 1 | Output-driven flag |

## Verification
The assertions check four things on every cycle: that a registered read makes the output driven on the next cycle, that a write cycle leaves it undriven, that two non-read cycles in a row release it, and that an active output enable or a synchronized sleep blocks data or accesses. The bench scenarios are the only way to show that the right word arrives: lane masking and the global override, the interleaved and linear burst orders with held counts, and the contents surviving deselected, gated-strobe and sleep cycles. These are compared against a bench model of the memory.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  // Kind of access registered in the input stage
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;

  // Low two address bits of a burst step
  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic       lin);
    return lin ? 2'(base + cnt) : (base ^ cnt);
  endfunction

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter  int AW     = 9,
  parameter  int LANES  = 4,
  parameter  int LANE_W = 9,
  localparam int W      = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     din,
  input  logic             sel_n,
  input  logic             sel_hi,
  input  logic             sel2_n,
  input  logic             strp_n,
  input  logic             strc_n,
  input  logic             adv_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             byte_wr_n,
  input  logic             all_wr_n,
  input  logic             lin_burst,
  input  logic             sleep_s,
  output acc_e             acc_kind,
  output logic [AW-1:0]    acc_addr,
  output logic [W-1:0]     acc_data,
  output logic [LANES-1:0] acc_mask
);

  logic             sel, start_c, start_p;
  logic [LANES-1:0] wmask;
  logic             active_q, active_n;
  logic [AW-1:0]    base_q, base_n;
  logic [1:0]       cnt_q, cnt_n;
  logic             lin_q, lin_n;
  acc_e             kind_n;
  logic [AW-1:0]    aaddr_n;
  logic             data_en;

  always_comb begin
    sel     = !sel_n && sel_hi && !sel2_n;
    start_c = !strc_n;
    start_p = !strp_n && !sel_n;
    if (!all_wr_n)       wmask = '1;
    else if (!byte_wr_n) wmask = ~lane_we_n;
    else                 wmask = '0;

    active_n = active_q;
    base_n   = base_q;
    cnt_n    = cnt_q;
    lin_n    = lin_q;
    kind_n   = ACC_NONE;
    aaddr_n  = acc_addr;

    if (!sleep_s) begin
      if (start_c || start_p) begin
        active_n = sel;
        if (sel) begin
          base_n  = addr;
          cnt_n   = '0;
          lin_n   = lin_burst;
          aaddr_n = addr;
          kind_n  = (|wmask) ? ACC_WR : ACC_RD;
        end
      end else if (active_q) begin
        if (!adv_n) cnt_n = 2'(cnt_q + 2'd1);
        aaddr_n = {base_q[AW-1:2], burst_lo(base_q[1:0], cnt_n, lin_q)};
        kind_n  = (|wmask) ? ACC_WR : ACC_RD;
      end
    end
    data_en = (kind_n == ACC_WR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      lin_q    <= 1'b0;
      acc_kind <= ACC_NONE;
      acc_addr <= '0;
    end else begin
      active_q <= active_n;
      base_q   <= base_n;
      cnt_q    <= cnt_n;
      lin_q    <= lin_n;
      acc_kind <= kind_n;
      acc_addr <= aaddr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_data <= '0;
      acc_mask <= '0;
    end else if (data_en) begin
      acc_data <= din;
      acc_mask <= wmask;
    end
  end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
  import sbsram_pkg::*;
#(
  parameter  int AW     = 9,
  parameter  int LANES  = 4,
  parameter  int LANE_W = 9,
  localparam int W      = LANES * LANE_W,
  localparam int DEPTH  = 1 << AW
) (
  input  logic             clk,
  input  acc_e             acc_kind,
  input  logic [AW-1:0]    acc_addr,
  input  logic [W-1:0]     acc_data,
  input  logic [LANES-1:0] acc_mask,
  output logic [W-1:0]     rd_word
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic              lane_we;

    assign lane_we = (acc_kind == ACC_WR) && acc_mask[g];

    always_ff @(posedge clk) begin
      if (lane_we) lane_mem[acc_addr] <= acc_data[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = lane_mem[acc_addr];
  end

endmodule

// File: rtl/sbsram_out.sv
module sbsram_out
  import sbsram_pkg::*;
#(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  acc_e         acc_kind,
  input  logic [W-1:0] rd_word,
  input  logic         oe_n,
  output logic [W-1:0] dout,
  output logic         dout_vld,
  output logic         drv_o
);

  logic         drv_q, drv_n;
  logic         ext_q, ext_n;
  logic         ld;
  logic [W-1:0] dq_q;

  always_comb begin
    ld    = 1'b0;
    drv_n = 1'b0;
    ext_n = 1'b0;
    unique case (acc_kind)
      ACC_RD: begin
        ld    = 1'b1;
        drv_n = 1'b1;
        ext_n = 1'b1;
      end
      ACC_WR: begin
        drv_n = 1'b0;
      end
      default: begin
        drv_n = drv_q && ext_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      drv_q <= drv_n;
      ext_q <= ext_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dq_q <= '0;
    else if (ld) dq_q <= rd_word;
  end

  assign dout_vld = drv_q && !oe_n;
  assign dout     = dout_vld ? dq_q : '0;
  assign drv_o    = drv_q;

endmodule

// File: rtl/sbsram_pipe.sv
module sbsram_pipe
  import sbsram_pkg::*;
#(
  parameter int AW     = 9,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [4*LANE_W-1:0] din,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel2_n,
  input  logic              strp_n,
  input  logic              strc_n,
  input  logic              adv_n,
  input  logic [3:0]        lane_we_n,
  input  logic              byte_wr_n,
  input  logic              all_wr_n,
  input  logic              lin_burst,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [4*LANE_W-1:0] dout,
  output logic              dout_vld
);

  localparam int LANES = 4;
  localparam int W     = LANES * LANE_W;

  logic [1:0]       rst_sync;
  logic             rst_q;
  logic [1:0]       zz_sync;
  logic             sleep_s;
  acc_e             acc_kind;
  logic [AW-1:0]    acc_addr;
  logic [W-1:0]     acc_data;
  logic [LANES-1:0] acc_mask;
  logic [W-1:0]     rd_word;
  logic             drv;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // sleep request crosses into the clock domain
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) zz_sync <= '0;
    else        zz_sync <= {zz_sync[0], sleep};
  end
  assign sleep_s = zz_sync[1];

  sbsram_ctrl #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q),
    .addr      (addr),
    .din       (din),
    .sel_n     (sel_n),
    .sel_hi    (sel_hi),
    .sel2_n    (sel2_n),
    .strp_n    (strp_n),
    .strc_n    (strc_n),
    .adv_n     (adv_n),
    .lane_we_n (lane_we_n),
    .byte_wr_n (byte_wr_n),
    .all_wr_n  (all_wr_n),
    .lin_burst (lin_burst),
    .sleep_s   (sleep_s),
    .acc_kind  (acc_kind),
    .acc_addr  (acc_addr),
    .acc_data  (acc_data),
    .acc_mask  (acc_mask)
  );

  sbsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .acc_kind (acc_kind),
    .acc_addr (acc_addr),
    .acc_data (acc_data),
    .acc_mask (acc_mask),
    .rd_word  (rd_word)
  );

  sbsram_out #(.W(W)) u_out (
    .clk      (clk),
    .rst_n    (rst_q),
    .acc_kind (acc_kind),
    .rd_word  (rd_word),
    .oe_n     (oe_n),
    .dout     (dout),
    .dout_vld (dout_vld),
    .drv_o    (drv)
  );

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk
  import sbsram_pkg::*;
#(
  parameter int W = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sleep_s,
  input logic         oe_n,
  input logic         strc_n,
  input logic         sel_hi,
  input acc_e         acc_kind,
  input logic         drv,
  input logic [W-1:0] dout,
  input logic         dout_vld
);

  // R8
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dout_vld && dout == '0));

  // R10
  sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_s |=> (acc_kind == ACC_NONE));

  // R1
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strc_n && !sel_hi) |=> (acc_kind == ACC_NONE));

  // R6
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_RD) |=> drv);

  // R5
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_WR) |=> !drv);

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind != ACC_RD && $past(acc_kind) != ACC_RD) |=> !drv);

endmodule

bind sbsram_pipe sbsram_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .sleep_s  (sleep_s),
  .oe_n     (oe_n),
  .strc_n   (strc_n),
  .sel_hi   (sel_hi),
  .acc_kind (acc_kind),
  .drv      (drv),
  .dout     (dout),
  .dout_vld (dout_vld)
);

// File: tb/tb_sbsram_pipe.sv
module tb_sbsram_pipe;

  localparam int CLK_PER = 10;
  localparam int AW      = 9;
  localparam int DEPTH   = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [35:0]   din;
  logic          sel_n, sel_hi, sel2_n, strp_n, strc_n, adv_n;
  logic [3:0]    lane_we_n;
  logic          byte_wr_n, all_wr_n, lin_burst, oe_n, sleep;
  logic [35:0]   dout;
  logic          dout_vld;

  logic [35:0]   mdl [DEPTH];
  int            n_chk = 0;
  int            n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;

  sbsram_pipe #(.AW(AW), .LANE_W(9)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
    .strp_n(strp_n), .strc_n(strc_n), .adv_n(adv_n),
    .lane_we_n(lane_we_n), .byte_wr_n(byte_wr_n), .all_wr_n(all_wr_n),
    .lin_burst(lin_burst), .oe_n(oe_n), .sleep(sleep),
    .dout(dout), .dout_vld(dout_vld)
  );

  function automatic logic [3:0] lanes_of(input logic gw_n, input logic bwe_n,
                                          input logic [3:0] ln);
    if (!gw_n)       return 4'hF;
    else if (!bwe_n) return ~ln;
    else             return 4'h0;
  endfunction

  function automatic logic [1:0] step_lo(input logic [1:0] b, input logic [1:0] c,
                                         input bit lin);
    return lin ? 2'(b + c) : (b ^ c);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [35:0] act,
                     input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    strc_n = 1'b0; strp_n = 1'b1; sel_n = 1'b1; sel_hi = 1'b1; sel2_n = 1'b0;
    adv_n = 1'b1; all_wr_n = 1'b1; byte_wr_n = 1'b1; lane_we_n = 4'hF;
  endtask

  task automatic op(input logic [AW-1:0] a, input logic [35:0] d, input logic gw_n,
                    input logic bwe_n, input logic [3:0] ln, input bit via_p,
                    input logic sn, input logic shi, input logic s2n, input bit take);
    logic [3:0] m;
    @(negedge clk);
    addr = a; din = d; all_wr_n = gw_n; byte_wr_n = bwe_n; lane_we_n = ln;
    sel_n = sn; sel_hi = shi; sel2_n = s2n; adv_n = 1'b1;
    strc_n = via_p; strp_n = !via_p;
    m = lanes_of(gw_n, bwe_n, ln);
    if (take)
      for (int j = 0; j < 4; j++)
        if (m[j]) mdl[a][j*9 +: 9] = d[j*9 +: 9];
    @(negedge clk);
    idle();
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic bwe_n, input logic [3:0] ln,
                        input string tag);
    @(negedge clk);
    addr = a; sel_n = 1'b0; sel_hi = 1'b1; sel2_n = 1'b0; strc_n = 1'b0; strp_n = 1'b1;
    all_wr_n = 1'b1; byte_wr_n = bwe_n; lane_we_n = ln; adv_n = 1'b1;
    @(negedge clk);
    idle();
    @(negedge clk);
    chk(dout_vld === 1'b1 && dout === mdl[a], tag, dout, mdl[a]);
  endtask

  task automatic burst(input logic [AW-1:0] b, input bit lin, input logic [3:0] advm,
                       input string tag);
    logic [AW-1:0] acc [5];
    logic [1:0]    c;
    c = 2'd0;
    acc[0] = b;
    for (int j = 1; j < 5; j++) begin
      if (advm[j-1]) c = 2'(c + 2'd1);
      acc[j] = {b[AW-1:2], step_lo(b[1:0], c, lin)};
    end
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (i >= 2)
        chk(dout_vld === 1'b1 && dout === mdl[acc[i-2]], tag, dout, mdl[acc[i-2]]);
      if (i == 0) begin
        addr = b; sel_n = 1'b0; sel_hi = 1'b1; sel2_n = 1'b0; strc_n = 1'b0;
        strp_n = 1'b1; lin_burst = lin; adv_n = 1'b1;
      end else if (i <= 4) begin
        strc_n = 1'b1; strp_n = 1'b1; adv_n = !advm[i-1];
      end else begin
        idle();
      end
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    logic [AW-1:0] a;
    logic [35:0]   d;
    void'($urandom(32'd1234));
    rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0; lin_burst = 1'b0;
    addr = '0; din = '0;
    idle();
    repeat (4) @(negedge clk);
    // R11 outputs quiet during reset
    chk(dout_vld === 1'b0 && dout === '0, "R11 in reset", dout, 36'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dout_vld === 1'b0 && dout === '0, "R11 after reset", dout, 36'h0);

    // preload every word through global writes (R3)
    for (int i = 0; i < DEPTH; i++)
      op(AW'(i), 36'(i) * 36'h1_0003 + 36'h3C3, 1'b0, 1'b1, 4'hF, 1'b0,
         1'b0, 1'b1, 1'b0, 1'b1);
    rd_chk(AW'(5), 1'b1, 4'hF, "R6 read latency");

    // R3 global write overrides lane enables that are all off
    op(AW'(10), 36'hA_BCDE_F012, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    rd_chk(AW'(10), 1'b1, 4'hF, "R3 global write");

    // R4 single lanes including parity bits
    op(AW'(11), 36'hF_FFFF_FFFF, 1'b1, 1'b0, 4'b1110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    rd_chk(AW'(11), 1'b1, 4'hF, "R4 lane 0");
    op(AW'(11), 36'h0_0000_0000, 1'b1, 1'b0, 4'b0111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    rd_chk(AW'(11), 1'b1, 4'hF, "R4 lane 3");

    // R5 lane gate open but no lane: read, contents unchanged
    op(AW'(12), 36'h1_2345_6789, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    rd_chk(AW'(12), 1'b0, 4'hF, "R5 empty lane mask reads");
    op(AW'(12), 36'h1_2345_6789, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    rd_chk(AW'(12), 1'b1, 4'hF, "R5 gate closed reads");

    // R1 each enable failing blocks the write
    op(AW'(20), 36'h0_DEAD_0001, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rd_chk(AW'(20), 1'b1, 4'hF, "R1 sel_hi low");
    op(AW'(20), 36'h0_DEAD_0002, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    rd_chk(AW'(20), 1'b1, 4'hF, "R1 sel2_n high");
    op(AW'(20), 36'h0_DEAD_0003, 1'b0, 1'b1, 4'hF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    rd_chk(AW'(20), 1'b1, 4'hF, "R1 sel_n high");

    // R2 processor strobe gated by sel_n
    op(AW'(21), 36'h5_5555_0001, 1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    rd_chk(AW'(21), 1'b1, 4'hF, "R2 proc strobe gated");
    op(AW'(21), 36'h5_5555_0002, 1'b0, 1'b1, 4'hF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    rd_chk(AW'(21), 1'b1, 4'hF, "R2 proc strobe starts");

    // R9 output lingers one cycle after deselect, then releases
    rd_chk(AW'(30), 1'b1, 4'hF, "R9 read");
    @(negedge clk);
    chk(dout_vld === 1'b1 && dout === mdl[30], "R9 extra cycle", dout, mdl[30]);
    @(negedge clk);
    chk(dout_vld === 1'b0, "R9 released", 36'(dout_vld), 36'h0);

    // R8 asynchronous output enable
    rd_chk(AW'(31), 1'b1, 4'hF, "R8 read");
    oe_n = 1'b1;
    #1;
    chk(dout_vld === 1'b0 && dout === '0, "R8 oe off", dout, 36'h0);
    oe_n = 1'b0;
    #1;
    chk(dout_vld === 1'b1 && dout === mdl[31], "R8 oe back", dout, mdl[31]);

    // R7 bursts: interleaved, linear, and with a held count
    burst(AW'(41), 1'b0, 4'b1111, "R7 interleaved");
    burst(AW'(47), 1'b1, 4'b1111, "R7 linear");
    burst(AW'(49), 1'b0, 4'b1101, "R7 hold");
    burst(AW'(54), 1'b1, 4'b1011, "R7 linear hold");

    // R10 sleep blocks accesses and keeps contents
    repeat (3) @(negedge clk);
    sleep = 1'b1;
    repeat (3) @(negedge clk);
    op(AW'(60), 36'h7_7777_7777, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    addr = AW'(60); sel_n = 1'b0; strc_n = 1'b0;
    @(negedge clk);
    idle();
    @(negedge clk);
    chk(dout_vld === 1'b0, "R10 no read while asleep", 36'(dout_vld), 36'h0);
    sleep = 1'b0;
    repeat (3) @(negedge clk);
    rd_chk(AW'(60), 1'b1, 4'hF, "R10 contents kept");

    // random mix of writes and reads (R4 R6)
    for (int k = 0; k < 400; k++) begin
      a = AW'($urandom % DEPTH);
      d = {4'($urandom), $urandom};
      if ($urandom % 3 == 0)
        rd_chk(a, 1'b1, 4'hF, "R6 random read");
      else
        op(a, d, ($urandom % 4) != 0, 1'($urandom), 4'($urandom), 1'b0,
           1'b0, 1'b1, 1'b0, 1'b1);
    end
    for (int k = 0; k < 40; k++)
      rd_chk(AW'($urandom % DEPTH), 1'b1, 4'hF, "R4 random readback");

    finish_run();
  end

endmodule